// File: doc/BRIEF.md
# Multi-Cycle Integer Immediate Sequencer

This block is a small 64-bit integer core. It fetches one 32-bit instruction at a time and executes the register-immediate arithmetic, logic, shift and compare group, plus the indirect jump-and-link. Every instruction walks the same four steps: fetch, decode, execute and retire. A new fetch therefore starts exactly four clock cycles after the one before it. The core has 32 registers of 64 bits, and register x0 always reads as zero.

The core drives a fetch address bus and a two-bit size code. The code marks the single cycle in which a 32-bit word is wanted. Memory must answer with zero wait states: the word on `instrData` is captured at the clock edge that closes the fetch cycle. A synchronous, active-high reset parks the core, clears every register and loads the program counter with a vector 256 bytes below the top of the 64-bit address space.

Top module: `imm_seq_core`

## Requirements
- R1: The first fetch after reset is released is at address 0xFFFF_FFFF_FFFF_FF00.
- R2: `fetchSize` is 2'b10 during a fetch cycle and 2'b00 otherwise. No other code ever appears, and each fetch lasts one cycle.
- R3: `fetchAddr` is zero in every cycle that is not a fetch cycle.
- R4: Consecutive fetches are exactly four cycles apart. After any instruction other than the jump, the next fetch address is the previous one plus 4.
- R5: No fetch occurs while `rst` is high. The first fetch comes in the cycle right after the first clock edge that samples `rst` low.
- R6: Opcode 7'b0010011 with funct3 000/100/110/111 writes rs1 plus, XOR, OR or AND the 12-bit immediate (instruction bits [31:20], sign-extended) to rd.
- R7: Opcode 7'b0010011 with funct3 001 shifts left, and with funct3 101 shifts right. The shift amount is instruction bits [25:20]. Instruction bit 30 set selects an arithmetic right shift, clear selects a logical one.
- R8: Opcode 7'b0010011 with funct3 010 writes 1 to rd if rs1 is below the sign-extended immediate as signed numbers, else 0. Funct3 011 makes the same comparison as unsigned numbers.
- R9: Opcode 7'b1100111 with funct3 000 writes PC+4 to rd and fetches next at (rs1 + sign-extended immediate) with bit 0 forced to zero.
- R10: x0 reads as zero and writes to it are dropped, so ADDI x0,x0,0 only moves the PC on by 4.
- R11: Any other opcode writes no register and only moves the PC on by 4.
- R12: Reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; holds the core idle |
| instrData | input | 32 | Instruction word, captured at the end of the fetch cycle |
| fetchSize | output | 2 | 2'b10 during a 32-bit fetch, 2'b00 otherwise |
| fetchAddr | output | 64 | Fetch address, zero outside fetch cycles |

## Verification
The core has no register read port, so every result is read back through a jump. The result is shifted left by one and used as a jump target, and the next fetch address then shows the value. A wrong ALU, a broken shift select or a mixed-up signed/unsigned compare shows up as a wrong fetch address. The bench covers several boundary cases:
- A negative immediate that must be sign-extended before AND or XOR.
- Right shifts by 60 and 63.
- A set-less-than where the signed and unsigned answers differ.
- A jump target with bit 0 set and a negative offset.
- Writes to x0.
- An unsupported opcode placed just before a register is read.
- A second reset after a register has been written, which must clear it.

It also times the first fetch after reset and every fetch-to-fetch gap. A sequencer that skips or repeats a state would shift those counts.

// File: rtl/imm_seq_pkg.sv
package imm_seq_pkg;

  typedef enum logic [2:0] {
    ST_START,
    ST_FETCH,
    ST_DECODE,
    ST_EXEC,
    ST_RETIRE
  } seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic fetch;    // drive the fetch bus
    logic latchIr;  // capture the instruction word
    logic readOps;  // read rs1, form the immediate
    logic execute;  // compute result and next pc
    logic retire;   // write rd, advance pc
  } seqStrobe_t;

  localparam logic [6:0] OPC_OPIMM = 7'b0010011;
  localparam logic [6:0] OPC_JALR  = 7'b1100111;

  localparam logic [2:0] F3_ADD  = 3'b000;
  localparam logic [2:0] F3_SLL  = 3'b001;
  localparam logic [2:0] F3_SLT  = 3'b010;
  localparam logic [2:0] F3_SLTU = 3'b011;
  localparam logic [2:0] F3_XOR  = 3'b100;
  localparam logic [2:0] F3_SR   = 3'b101;
  localparam logic [2:0] F3_OR   = 3'b110;
  localparam logic [2:0] F3_AND  = 3'b111;

  localparam logic [1:0] SIZE_NONE = 2'b00;
  localparam logic [1:0] SIZE_WORD = 2'b10;

endpackage

// File: rtl/imm_seq_ctrl.sv
module imm_seq_ctrl
  import imm_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  output seqStrobe_t strobe
);

  seqState_t state, stateNext;

  always_comb begin
    unique case (state)
      ST_START:  stateNext = ST_FETCH;
      ST_FETCH:  stateNext = ST_DECODE;
      ST_DECODE: stateNext = ST_EXEC;
      ST_EXEC:   stateNext = ST_RETIRE;
      ST_RETIRE: stateNext = ST_FETCH;
      default:   stateNext = ST_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_START;
    else     state <= stateNext;
  end

  always_comb begin
    strobe         = '0;
    strobe.fetch   = (state == ST_FETCH);
    strobe.latchIr = (state == ST_FETCH);
    strobe.readOps = (state == ST_DECODE);
    strobe.execute = (state == ST_EXEC);
    strobe.retire  = (state == ST_RETIRE);
  end

endmodule

// File: rtl/imm_seq_alu.sv
module imm_seq_alu
  import imm_seq_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] immV,
  input  logic [2:0]      funct3,
  output logic [XLEN-1:0] aluOut
);

  localparam int SHW = $clog2(XLEN);

  logic [SHW-1:0] shamt;
  logic           arith;

  assign shamt = immV[SHW-1:0];  // instruction bits [20 +: SHW]
  assign arith = immV[10];       // instruction bit 30

  always_comb begin
    unique case (funct3)
      F3_ADD:  aluOut = srcA + immV;
      F3_SLT:  aluOut = {{(XLEN-1){1'b0}}, ($signed(srcA) < $signed(immV))};
      F3_SLTU: aluOut = {{(XLEN-1){1'b0}}, (srcA < immV)};
      F3_XOR:  aluOut = srcA ^ immV;
      F3_OR:   aluOut = srcA | immV;
      F3_AND:  aluOut = srcA & immV;
      F3_SLL:  aluOut = srcA << shamt;
      F3_SR:   aluOut = arith ? XLEN'($signed(srcA) >>> shamt) : (srcA >> shamt);
      default: aluOut = '0;
    endcase
  end

endmodule

// File: rtl/imm_seq_dpath.sv
module imm_seq_dpath
  import imm_seq_pkg::*;
#(
  parameter int              XLEN      = 64,
  parameter int              REGS      = 32,
  parameter logic [XLEN-1:0] RESET_VEC = {{(XLEN-8){1'b1}}, 8'h00}
) (
  input  logic            clk,
  input  logic            rst,
  input  seqStrobe_t      strobe,
  input  logic [31:0]     instrData,
  output logic [1:0]      fetchSize,
  output logic [XLEN-1:0] fetchAddr
);

  localparam int              RIDX       = $clog2(REGS);
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);
  localparam logic [XLEN-1:0] ALIGN_MASK = {{(XLEN-1){1'b1}}, 1'b0};

  logic [XLEN-1:0] pc, opA, immV, result, nextPc, aluOut;
  logic [31:0]     ir;
  logic            wrEn;
  logic [XLEN-1:0] rf [REGS];

  logic [RIDX-1:0] rdIdx, rs1Idx;
  logic            isOpImm, isJalr;

  assign rdIdx   = ir[7 +: RIDX];
  assign rs1Idx  = ir[15 +: RIDX];
  assign isOpImm = (ir[6:0] == OPC_OPIMM);
  assign isJalr  = (ir[6:0] == OPC_JALR) && (ir[14:12] == 3'b000);

  // register file: entry 0 is a constant, the rest share one write port
  for (genvar g = 0; g < REGS; g++) begin : gReg
    if (g == 0) begin : gZero
      assign rf[g] = '0;
    end else begin : gLive
      always_ff @(posedge clk) begin
        if (rst)
          rf[g] <= '0;
        else if (strobe.retire && wrEn && (rdIdx == RIDX'(g)))
          rf[g] <= result;
      end
    end
  end

  imm_seq_alu #(.XLEN(XLEN)) uAlu (
    .srcA   (opA),
    .immV   (immV),
    .funct3 (ir[14:12]),
    .aluOut (aluOut)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= RESET_VEC;
      ir     <= '0;
      opA    <= '0;
      immV   <= '0;
      result <= '0;
      nextPc <= '0;
      wrEn   <= 1'b0;
    end else begin
      if (strobe.latchIr) ir <= instrData;
      if (strobe.readOps) begin
        opA  <= rf[rs1Idx];
        immV <= {{(XLEN-12){ir[31]}}, ir[31:20]};
      end
      if (strobe.execute) begin
        if (isJalr) begin
          result <= pc + INSN_BYTES;
          nextPc <= (opA + immV) & ALIGN_MASK;
          wrEn   <= 1'b1;
        end else begin
          result <= aluOut;
          nextPc <= pc + INSN_BYTES;
          wrEn   <= isOpImm;
        end
      end
      if (strobe.retire) pc <= nextPc;
    end
  end

  assign fetchSize = strobe.fetch ? SIZE_WORD : SIZE_NONE;
  assign fetchAddr = strobe.fetch ? pc : '0;

endmodule

// File: rtl/imm_seq_core.sv
module imm_seq_core
  import imm_seq_pkg::*;
#(
  parameter int              XLEN      = 64,
  parameter int              REGS      = 32,
  parameter logic [XLEN-1:0] RESET_VEC = {{(XLEN-8){1'b1}}, 8'h00}
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     instrData,
  output logic [1:0]      fetchSize,
  output logic [XLEN-1:0] fetchAddr
);

  seqStrobe_t strobe;

  imm_seq_ctrl uCtrl (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe)
  );

  imm_seq_dpath #(.XLEN(XLEN), .REGS(REGS), .RESET_VEC(RESET_VEC)) uDpath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .instrData (instrData),
    .fetchSize (fetchSize),
    .fetchAddr (fetchAddr)
  );

endmodule

// File: rtl/imm_seq_chk.sv
module imm_seq_chk #(
  parameter int              XLEN      = 64,
  parameter logic [XLEN-1:0] RESET_VEC = {{(XLEN-8){1'b1}}, 8'h00}
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      fetchSize,
  input logic [XLEN-1:0] fetchAddr
);

  logic       isFetch;
  logic [2:0] sinceFetch;
  logic       seenFetch;

  assign isFetch = (fetchSize == 2'b10);

  // idle cycles since the last fetch, saturating
  always_ff @(posedge clk) begin
    if (rst) begin
      sinceFetch <= '0;
      seenFetch  <= 1'b0;
    end else if (isFetch) begin
      sinceFetch <= '0;
      seenFetch  <= 1'b1;
    end else if (sinceFetch != 3'd7) begin
      sinceFetch <= sinceFetch + 3'd1;
    end
  end

  AST_FIRST_FETCH: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !rst) |=> (isFetch && fetchAddr == RESET_VEC)); // R1

  AST_SIZE_CODE: assert property (@(posedge clk) disable iff (rst)
    (fetchSize == 2'b00 || fetchSize == 2'b10)); // R2

  AST_ONE_CYCLE_FETCH: assert property (@(posedge clk) disable iff (rst)
    isFetch |=> !isFetch); // R2

  AST_IDLE_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
    !isFetch |-> (fetchAddr == '0)); // R3

  AST_FETCH_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (isFetch && seenFetch) |-> (sinceFetch == 3'd3)); // R4

  AST_QUIET_IN_RESET: assert property (@(posedge clk)
    rst |=> (fetchSize == 2'b00)); // R5

  AST_FETCH_EVEN: assert property (@(posedge clk) disable iff (rst)
    isFetch |-> !fetchAddr[0]); // R9

endmodule

bind imm_seq_core imm_seq_chk #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) uChk (
  .clk       (clk),
  .rst       (rst),
  .fetchSize (fetchSize),
  .fetchAddr (fetchAddr)
);

// File: tb/tb_imm_seq_core.sv
module tb_imm_seq_core;

  localparam logic [63:0] RESET_VEC = 64'hFFFF_FFFF_FFFF_FF00;
  localparam logic [6:0]  OPIMM = 7'b0010011;
  localparam logic [6:0]  JALR  = 7'b1100111;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instrData = '0;
  logic [1:0]  fetchSize;
  logic [63:0] fetchAddr;

  imm_seq_core dut (
    .clk       (clk),
    .rst       (rst),
    .instrData (instrData),
    .fetchSize (fetchSize),
    .fetchAddr (fetchAddr)
  );

  always #5 clk = ~clk;

  int          nChecks = 0;
  int          nErr    = 0;
  logic [63:0] expPc;
  string       pendTag = "R1";
  bit          finished = 1'b0;

  typedef struct packed {
    logic [2:0]  f3;
    logic [11:0] immT;
    logic [11:0] seed;
    logic [63:0] expV;
    logic [3:0]  req;
  } vec_t;

  // x1 = sext(seed); x2 = op(x1, immT); result seen as jump target x2<<1
  localparam vec_t VECS [15] = '{
    '{3'b000, 12'h005, 12'h007, 64'd12,                  4'd6},  // R6 add
    '{3'b000, 12'hFFD, 12'h001, 64'hFFFF_FFFF_FFFF_FFFE, 4'd6},  // R6 negative add
    '{3'b111, 12'h03C, 12'h0F0, 64'h030,                 4'd6},  // R6 and
    '{3'b111, 12'hF0F, 12'h7FF, 64'h70F,                 4'd6},  // R6 and, negative imm
    '{3'b110, 12'h00F, 12'h0F0, 64'h0FF,                 4'd6},  // R6 or
    '{3'b100, 12'h0FF, 12'h555, 64'h5AA,                 4'd6},  // R6 xor
    '{3'b100, 12'hFFF, 12'h123, 64'hFFFF_FFFF_FFFF_FEDC, 4'd6},  // R6 xor with -1
    '{3'b001, 12'h028, 12'h001, 64'h0000_0100_0000_0000, 4'd7},  // R7 sll 40
    '{3'b101, 12'h03C, 12'hFFF, 64'hF,                   4'd7},  // R7 srl 60
    '{3'b101, 12'h03F, 12'hFFF, 64'h1,                   4'd7},  // R7 srl 63
    '{3'b101, 12'h402, 12'hFF0, 64'hFFFF_FFFF_FFFF_FFFC, 4'd7},  // R7 sra 2
    '{3'b010, 12'h003, 12'hFFB, 64'h1,                   4'd8},  // R8 slt signed true
    '{3'b011, 12'h003, 12'hFFB, 64'h0,                   4'd8},  // R8 sltu same operands false
    '{3'b011, 12'hFFF, 12'h002, 64'h1,                   4'd8},  // R8 sltu vs all-ones
    '{3'b010, 12'h005, 12'h005, 64'h0,                   4'd8}   // R8 slt equal
  };

  function automatic logic [31:0] iType(input logic [11:0] imm, input int rs1,
                                        input logic [2:0] f3, input int rd,
                                        input logic [6:0] opc);
    logic [4:0] s, d;
    s = rs1[4:0];
    d = rd[4:0];
    return {imm, s, f3, d, opc};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // wait for the next fetch, check its timing and address, then supply ins
  task automatic issue(input logic [31:0] ins, input int gapExp);
    int gap;
    bit idleOk;
    idleOk = 1'b1;
    @(negedge clk);
    gap = 1;
    while (fetchSize == 2'b00 && gap < 40) begin
      if (fetchAddr != '0) idleOk = 1'b0;
      @(negedge clk);
      gap++;
    end
    check(idleOk, "R3", "idle address nonzero", 64'(idleOk), 64'd1);
    check(gap == gapExp, (gapExp == 1) ? "R5" : "R4", "fetch gap",
          64'(gap), 64'(gapExp));
    check(fetchSize == 2'b10, "R2", "fetch size", 64'(fetchSize), 64'd2);
    check(fetchAddr == expPc, pendTag, "fetch address", fetchAddr, expPc);
    instrData = ins;
    expPc     = expPc + 64'd4;
    pendTag   = "R4";
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(fetchSize == 2'b00 && fetchAddr == '0, "R5", "activity in reset",
            fetchAddr, 64'd0);
    end
    rst     = 1'b0;
    expPc   = RESET_VEC;
    pendTag = "R1";
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nErr++;
      nChecks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 first fetch, R12 cleared x7 used as jump base
    issue(iType(12'h020, 7, 3'b000, 0, JALR), 1);
    expPc = 64'h20; pendTag = "R12";

    // table walk
    for (int k = 0; k < 15; k++) begin
      issue(iType(VECS[k].seed, 0, 3'b000, 1, OPIMM), 4);
      issue(iType(VECS[k].immT, 1, VECS[k].f3, 2, OPIMM), 4);
      issue(iType(12'h001, 2, 3'b001, 3, OPIMM), 4);
      issue(iType(12'h000, 3, 3'b000, 0, JALR), 4);
      expPc   = VECS[k].expV << 1;
      pendTag = $sformatf("R%0d", VECS[k].req);
    end

    // R10 no-op advances only the pc; x0 write dropped
    issue(iType(12'h000, 0, 3'b000, 0, OPIMM), 4);
    pendTag = "R10";
    issue(iType(12'h055, 0, 3'b000, 0, OPIMM), 4);
    issue(iType(12'h100, 0, 3'b000, 0, JALR), 4);
    expPc = 64'h100; pendTag = "R10";

    // R9 link and odd target, then negative offset back through the link
    issue(iType(12'h201, 0, 3'b000, 5, JALR), 4);
    expPc = 64'h200; pendTag = "R9";
    issue(iType(12'hFFC, 5, 3'b000, 0, JALR), 4);
    expPc = 64'h100; pendTag = "R9";

    // R11 unsupported opcode leaves x6 alone and steps the pc
    issue(iType(12'h040, 0, 3'b000, 6, OPIMM), 4);
    issue({7'b0, 5'd0, 5'd0, 3'b000, 5'd6, 7'b0110011}, 4);
    pendTag = "R11";
    issue(iType(12'h000, 6, 3'b000, 0, JALR), 4);
    expPc = 64'h40; pendTag = "R11";

    // R12 reset clears a written register
    issue(iType(12'h3A0, 0, 3'b000, 7, OPIMM), 4);
    issue(iType(12'h000, 0, 3'b000, 0, OPIMM), 4);
    doReset();
    issue(iType(12'h020, 7, 3'b000, 0, JALR), 1);
    expPc = 64'h20; pendTag = "R12";
    issue(iType(12'h000, 0, 3'b000, 0, OPIMM), 4);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule